// File: doc/BRIEF.md
# Codec Register Access Port

This block sits between a host register bus and a serial audio codec link. It lets software read and write the 16-bit registers of a primary or secondary codec, one access at a time. Software checks a semaphore bit until it reads clear, loads the data word (for a write), and then writes a command address word. That single address write picks read or write, picks the codec, and starts the transfer.

While the transfer runs, the semaphore reads busy. Completion shows up as a read-done or write-done flag in a status word, next to a live codec-ready bit. Returned read data and the address it belongs to are kept in read-back registers.

On the codec side the block raises a request with the register index, direction, codec select and write data. It holds that request until the codec side acknowledges, or until a cycle budget runs out.

Top module: `cap_codec_port`

## Requirements
- R1: After reset the following all read zero: the semaphore word, the done flags, the read-back registers and the bus read data, and `link_req` is low.
- R2: A bus write to the command address offset 0x04 while idle starts a transaction. From the next cycle `link_req` is high and the semaphore word at offset 0x14 reads with bit 31 set. `link_idx`, `link_rnw` and `link_sec` carry bits 6:0, 7 and 8 of the written word, and offset 0x04 reads back that word.
- R3: A write transaction carries on `link_wdata` the value last written to the command data offset 0x00 before the launch. Later data writes do not change it while the transaction is in flight.
- R4: When `link_ack` is sampled high during a write transaction, the next cycle shows `link_req` low, semaphore bit 31 clear and write-done (bit 0 of the status word at offset 0x10) set.
- R5: When `link_ack` is sampled high during a read transaction, the following happens in the same edge:
  - `link_rdata` is stored in the read data register at offset 0x08.
  - Read-done (status bit 1) is set.
  - The register at offset 0x0C takes the launched word: codec select in bit 8, bit 7 set, and the index in bits 6:0.
- R6: Launching a transaction clears both read-done and write-done.
- R7: A command address write while a transaction is in flight is ignored. The index, direction, codec select and data on the link stay unchanged, and no second transaction follows.
- R8: If no acknowledge arrives, the transaction ends after exactly TMO_CYC cycles of `link_req` high. The semaphore then clears and neither done flag is set.
- R9: Status bit 3 reports the `codec_rdy` input as sampled at the read request.
- R10: Bus read data is registered: it appears in the cycle after a read request and holds until the next read. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| codec_rdy | input | 1 | Codec-ready indication from the link |
| link_req | output | 1 | Transaction request, held until acknowledge or timeout |
| link_rnw | output | 1 | 1 = read, 0 = write |
| link_sec | output | 1 | 1 = secondary codec |
| link_idx | output | 7 | Codec register index |
| link_wdata | output | 16 | Write data for the codec |
| link_ack | input | 1 | One-cycle completion from the codec side |
| link_rdata | input | 16 | Read data, valid with `link_ack` |

## Verification
Each result is due a fixed number of edges after the stimulus that causes it:
- A launch is visible on the link one cycle after the address-write edge.
- Done flags and read-back data change at the edge that samples `link_ack`.
- Bus read data is valid one cycle after the read strobe.
- A transaction with no acknowledge drops after exactly TMO_CYC request cycles.

The bench keeps a behavioural model that advances at each rising edge from the same sampled inputs. It compares the link outputs and the read data just after that edge. The directed checks drive at falling edges and read results at the next falling edge, so they always sample after the register that produced them.

// File: rtl/cap_pkg.sv
// Package: shared offsets, bit positions and state type for the codec
// register access port. Assumes a byte-addressed host bus.
package cap_pkg;
    localparam logic [7:0] OFS_CMD_DATA = 8'h00;
    localparam logic [7:0] OFS_CMD_ADDR = 8'h04;
    localparam logic [7:0] OFS_RD_DATA  = 8'h08;
    localparam logic [7:0] OFS_RD_ADDR  = 8'h0C;
    localparam logic [7:0] OFS_STATUS   = 8'h10;
    localparam logic [7:0] OFS_SEM      = 8'h14;

    localparam int ST_WDONE_BIT = 0;
    localparam int ST_RDONE_BIT = 1;
    localparam int ST_RDY_BIT   = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } txn_state_e;
endpackage

// File: rtl/cap_txn_fsm.sv
// Transaction engine: accepts a launch when idle, holds the codec request
// with latched fields until acknowledge or until TMO_CYC cycles pass.
// Assumes link_ack is a single-cycle pulse given only while link_req is high.
module cap_txn_fsm #(
    parameter int IDX_W   = 7,
    parameter int DATA_W  = 16,
    parameter int TMO_CYC = 64,
    localparam int WORD_W = IDX_W + 2,
    localparam int CNT_W  = $clog2(TMO_CYC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [WORD_W-1:0] start_word,
    input  logic [DATA_W-1:0] start_data,
    input  logic              link_ack,
    output logic              launched,
    output logic              busy,
    output logic              done_rd,
    output logic              done_wr,
    output logic [WORD_W-1:0] cur_word,
    output logic [DATA_W-1:0] cur_data
);
    import cap_pkg::*;

    txn_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign busy     = (state_q == ST_WAIT);
    assign launched = start_req && (state_q == ST_IDLE);
    assign expire   = (cnt_q == CNT_W'(TMO_CYC - 1));
    assign done_rd  = busy && link_ack && cur_word[IDX_W];
    assign done_wr  = busy && link_ack && !cur_word[IDX_W];

    // Sequence launch, wait, and end on acknowledge or on budget expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            cur_word <= '0;
            cur_data <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        state_q  <= ST_WAIT;
                        cnt_q    <= '0;
                        cur_word <= start_word;
                        cur_data <= start_data;
                    end
                end
                ST_WAIT: begin
                    if (link_ack || expire) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cap_cmd_regs.sv
// Host-visible register file: command data, launch decode, done flags,
// read-back capture and a registered read mux. Assumes one bus access per
// cycle, so a launch and a completion never share an edge.
module cap_cmd_regs #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16,
    parameter int BUS_W  = 32,
    parameter int OFS_W  = 8,
    localparam int WORD_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              codec_rdy,
    input  logic              launched,
    input  logic              busy,
    input  logic              done_rd,
    input  logic              done_wr,
    input  logic [WORD_W-1:0] cur_word,
    input  logic [DATA_W-1:0] link_rdata,
    output logic              addr_wr_stb,
    output logic [WORD_W-1:0] addr_wr_word,
    output logic [DATA_W-1:0] cmd_data,
    output logic              rd_done,
    output logic              wr_done
);
    import cap_pkg::*;

    logic [DATA_W-1:0] rd_data_q;
    logic [WORD_W-1:0] rd_addr_q;
    logic [WORD_W-1:0] last_word_q;
    logic [BUS_W-1:0]  rd_mux;
    logic [BUS_W-1:0]  status_w;
    logic              data_wr_stb;
    logic              unused_wbits;

    assign addr_wr_stb  = bus_sel && bus_wr && (bus_addr == OFS_W'(OFS_CMD_ADDR));
    assign data_wr_stb  = bus_sel && bus_wr && (bus_addr == OFS_W'(OFS_CMD_DATA));
    assign addr_wr_word = bus_wdata[WORD_W-1:0];
    assign unused_wbits = ^bus_wdata[BUS_W-1:DATA_W];

    // Assemble the status word from the flags and the ready input.
    always_comb begin
        status_w               = '0;
        status_w[ST_WDONE_BIT] = wr_done;
        status_w[ST_RDONE_BIT] = rd_done;
        status_w[ST_RDY_BIT]   = codec_rdy;
    end

    // Select the register addressed by a read; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_W'(OFS_CMD_DATA): rd_mux = BUS_W'(cmd_data);
            OFS_W'(OFS_CMD_ADDR): rd_mux = BUS_W'(last_word_q);
            OFS_W'(OFS_RD_DATA):  rd_mux = BUS_W'(rd_data_q);
            OFS_W'(OFS_RD_ADDR):  rd_mux = BUS_W'(rd_addr_q);
            OFS_W'(OFS_STATUS):   rd_mux = status_w;
            OFS_W'(OFS_SEM):      rd_mux = {busy, {(BUS_W-1){1'b0}}};
            default:              rd_mux = '0;
        endcase
    end

    // Update stored registers and flags, and register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_data    <= '0;
            rd_data_q   <= '0;
            rd_addr_q   <= '0;
            last_word_q <= '0;
            rd_done     <= 1'b0;
            wr_done     <= 1'b0;
            bus_rdata   <= '0;
        end else begin
            if (data_wr_stb) begin
                cmd_data <= bus_wdata[DATA_W-1:0];
            end
            if (launched) begin
                rd_done     <= 1'b0;
                wr_done     <= 1'b0;
                last_word_q <= addr_wr_word;
            end
            if (done_rd) begin
                rd_done   <= 1'b1;
                rd_data_q <= link_rdata;
                rd_addr_q <= cur_word;
            end
            if (done_wr) begin
                wr_done <= 1'b1;
            end
            if (bus_sel && !bus_wr) begin
                bus_rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/cap_codec_port.sv
// Top of the codec register access port: ties the host register file to the
// transaction engine and drives the codec-side request interface.
// Assumes the codec side answers each request with one link_ack pulse.
module cap_codec_port #(
    parameter int IDX_W   = 7,
    parameter int DATA_W  = 16,
    parameter int BUS_W   = 32,
    parameter int OFS_W   = 8,
    parameter int TMO_CYC = 64,
    localparam int WORD_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              codec_rdy,
    output logic              link_req,
    output logic              link_rnw,
    output logic              link_sec,
    output logic [IDX_W-1:0]  link_idx,
    output logic [DATA_W-1:0] link_wdata,
    input  logic              link_ack,
    input  logic [DATA_W-1:0] link_rdata
);
    logic              addr_wr_stb;
    logic [WORD_W-1:0] addr_wr_word;
    logic [DATA_W-1:0] cmd_data;
    logic              launched;
    logic              busy;
    logic              done_rd;
    logic              done_wr;
    logic [WORD_W-1:0] cur_word;
    logic              rd_done;
    logic              wr_done;

    assign link_req = busy;
    assign link_idx = cur_word[IDX_W-1:0];
    assign link_rnw = cur_word[IDX_W];
    assign link_sec = cur_word[IDX_W+1];

    cap_cmd_regs #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .OFS_W(OFS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .codec_rdy(codec_rdy),
        .launched(launched), .busy(busy),
        .done_rd(done_rd), .done_wr(done_wr),
        .cur_word(cur_word), .link_rdata(link_rdata),
        .addr_wr_stb(addr_wr_stb), .addr_wr_word(addr_wr_word),
        .cmd_data(cmd_data), .rd_done(rd_done), .wr_done(wr_done)
    );

    cap_txn_fsm #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_req(addr_wr_stb), .start_word(addr_wr_word),
        .start_data(cmd_data), .link_ack(link_ack),
        .launched(launched), .busy(busy),
        .done_rd(done_rd), .done_wr(done_wr),
        .cur_word(cur_word), .cur_data(link_wdata)
    );
endmodule

// File: rtl/cap_codec_port_chk.sv
// Checker for the codec register access port, bound to the top module.
// Assumes the default offsets of cap_pkg.
module cap_codec_port_chk #(
    parameter int IDX_W   = 7,
    parameter int DATA_W  = 16,
    parameter int OFS_W   = 8,
    parameter int TMO_CYC = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [OFS_W-1:0]  bus_addr,
    input logic              link_req,
    input logic              link_rnw,
    input logic              link_sec,
    input logic [IDX_W-1:0]  link_idx,
    input logic [DATA_W-1:0] link_wdata,
    input logic              link_ack,
    input logic              rd_done,
    input logic              wr_done
);
    import cap_pkg::*;

    localparam int RUN_W = $clog2(TMO_CYC + 2) + 1;

    logic             addr_wr;
    logic [RUN_W-1:0] run_q;

    assign addr_wr = bus_sel && bus_wr && (bus_addr == OFS_W'(OFS_CMD_ADDR));

    // Count consecutive cycles of an outstanding request.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (link_req) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && !link_req) |=> link_req);

    a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        link_req |=> ($stable(link_idx) && $stable(link_rnw) &&
                      $stable(link_sec) && $stable(link_wdata)));

    a_r4_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req && link_ack) |=> !link_req);

    a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && !link_req) |=> (!rd_done && !wr_done));

    a_r8_budget: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(TMO_CYC));
endmodule

bind cap_codec_port cap_codec_port_chk #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .TMO_CYC(TMO_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .link_req(link_req), .link_rnw(link_rnw),
    .link_sec(link_sec), .link_idx(link_idx), .link_wdata(link_wdata),
    .link_ack(link_ack), .rd_done(rd_done), .wr_done(wr_done)
);

// File: tb/tb_cap_codec_port.sv
module tb_cap_codec_port;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        codec_rdy = 1'b0;
    logic        link_req, link_rnw, link_sec;
    logic [6:0]  link_idx;
    logic [15:0] link_wdata;
    logic        link_ack = 1'b0;
    logic [15:0] link_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    int resp_lat = 3;
    int resp_cnt = 0;

    cap_codec_port #(.TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .codec_rdy(codec_rdy), .link_req(link_req), .link_rnw(link_rnw),
        .link_sec(link_sec), .link_idx(link_idx), .link_wdata(link_wdata),
        .link_ack(link_ack), .link_rdata(link_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] codec_answer(input logic sec, input logic [6:0] idx);
        return 16'hC000 | {8'h00, sec, idx};
    endfunction

    // Behavioural codec: acknowledges resp_lat falling edges after a request.
    always @(negedge clk) begin
        if (!rst_n) begin
            link_ack = 1'b0;
            resp_cnt = 0;
        end else if (link_ack) begin
            link_ack = 1'b0;
            resp_cnt = 0;
        end else if (link_req) begin
            resp_cnt++;
            if (resp_cnt >= resp_lat) begin
                link_ack   = 1'b1;
                link_rdata = codec_answer(link_sec, link_idx);
            end
        end else begin
            resp_cnt = 0;
        end
    end

    // Reference model state.
    logic        m_busy = 0;
    int          m_cnt = 0;
    logic [8:0]  m_word = '0;
    logic [15:0] m_wd = '0, m_data = '0, m_rdat = '0;
    logic [8:0]  m_raddr = '0;
    logic        m_rdd = 0, m_wrd = 0;
    logic [31:0] m_rdata = '0;

    // Advance the model at each edge and compare outputs just after it.
    always @(posedge clk) begin
        logic [31:0] mux;
        case (bus_addr)
            8'h00: mux = {16'h0, m_data};
            8'h04: mux = {23'h0, m_word};
            8'h08: mux = {16'h0, m_rdat};
            8'h0C: mux = {23'h0, m_raddr};
            8'h10: mux = {28'h0, codec_rdy, 1'b0, m_rdd, m_wrd};
            8'h14: mux = {m_busy, 31'h0};
            default: mux = '0;
        endcase
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_word = '0; m_wd = '0; m_data = '0;
            m_rdat = '0; m_raddr = '0; m_rdd = 0; m_wrd = 0; m_rdata = '0;
        end else begin
            if (bus_sel && !bus_wr) m_rdata = mux;
            if (m_busy) begin
                if (link_ack) begin
                    m_busy = 0;
                    if (m_word[7]) begin
                        m_rdd = 1; m_rdat = link_rdata; m_raddr = m_word;
                    end else begin
                        m_wrd = 1;
                    end
                end else if (m_cnt == TMO - 1) begin
                    m_busy = 0;
                end else begin
                    m_cnt++;
                end
            end else if (bus_sel && bus_wr && bus_addr == 8'h04) begin
                m_busy = 1; m_cnt = 0; m_word = bus_wdata[8:0];
                m_wd = m_data; m_rdd = 0; m_wrd = 0;
            end
            if (bus_sel && bus_wr && bus_addr == 8'h00) m_data = bus_wdata[15:0];
        end
        #1;
        check(link_req === m_busy, "R2/R8 model link_req", 32'(link_req), 32'(m_busy));
        check(bus_rdata === m_rdata, "R10 model bus_rdata", bus_rdata, m_rdata);
        if (m_busy) begin
            check({link_sec, link_rnw, link_idx} === m_word, "R7 model link fields",
                  32'({link_sec, link_rnw, link_idx}), 32'(m_word));
            check(link_wdata === m_wd, "R3 model link_wdata", 32'(link_wdata), 32'(m_wd));
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check(link_req === 1'b0, "R1 link_req after reset", 32'(link_req), 0);
        bus_read(8'h10, v); check(v === 32'h0, "R1 status after reset", v, 32'h0);
        bus_read(8'h14, v); check(v === 32'h0, "R1 semaphore after reset", v, 32'h0);
        bus_read(8'h08, v); check(v === 32'h0, "R1 read data after reset", v, 32'h0);
        // R9: ready bit follows input
        codec_rdy = 1;
        bus_read(8'h10, v); check(v === 32'h8, "R9 status ready", v, 32'h8);
        // R2 R3 R4: secondary-codec write
        bus_write(8'h00, 32'h0000_1234);
        bus_write(8'h04, 32'h0000_0105);
        check({link_req, link_sec, link_rnw, link_idx} === 10'b1_1_0_0000101,
              "R2 launch fields", 32'({link_req, link_sec, link_rnw, link_idx}), 32'h305);
        check(link_wdata === 16'h1234, "R3 write data", 32'(link_wdata), 32'h1234);
        bus_read(8'h14, v); check(v === 32'h8000_0000, "R2 semaphore busy", v, 32'h8000_0000);
        bus_write(8'h00, 32'h0000_BEEF);
        check(link_wdata === 16'h1234, "R3 data held in flight", 32'(link_wdata), 32'h1234);
        repeat (6) @(negedge clk);
        bus_read(8'h10, v); check(v === 32'h9, "R4 write done", v, 32'h9);
        bus_read(8'h14, v); check(v === 32'h0, "R4 semaphore clear", v, 32'h0);
        bus_read(8'h04, v); check(v === 32'h105, "R2 address readback", v, 32'h105);
        // R5 R6: primary-codec read
        bus_write(8'h04, 32'h0000_00AA);
        bus_read(8'h10, v); check(v === 32'h8, "R6 flags cleared on launch", v, 32'h8);
        repeat (6) @(negedge clk);
        bus_read(8'h10, v); check(v === 32'hA, "R5 read done", v, 32'hA);
        bus_read(8'h08, v); check(v === 32'(codec_answer(1'b0, 7'h2A)), "R5 read data",
                                  v, 32'(codec_answer(1'b0, 7'h2A)));
        bus_read(8'h0C, v); check(v === 32'hAA, "R5 read address", v, 32'hAA);
        // R7: address write while busy is ignored
        resp_lat = 6;
        bus_write(8'h04, 32'h0000_0191);
        bus_write(8'h04, 32'h0000_0033);
        check({link_sec, link_rnw, link_idx} === 9'h191, "R7 fields unchanged",
              32'({link_sec, link_rnw, link_idx}), 32'h191);
        repeat (10) @(negedge clk);
        check(link_req === 1'b0, "R7 no second transaction", 32'(link_req), 0);
        bus_read(8'h10, v); check(v === 32'hA, "R7 only read done", v, 32'hA);
        bus_read(8'h0C, v); check(v === 32'h191, "R7 read address kept", v, 32'h191);
        bus_read(8'h08, v); check(v === 32'(codec_answer(1'b1, 7'h11)), "R5 secondary read data",
                                  v, 32'(codec_answer(1'b1, 7'h11)));
        // R8: timeout with no acknowledge
        resp_lat = 100000;
        bus_write(8'h04, 32'h0000_0005);
        n = 0;
        while (link_req && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == TMO, "R8 request length", 32'(n), 32'(TMO));
        bus_read(8'h10, v); check(v === 32'h8, "R8 no done flag", v, 32'h8);
        bus_read(8'h14, v); check(v === 32'h0, "R8 semaphore clear", v, 32'h0);
        // R4 after timeout: a new write completes
        resp_lat = 2;
        bus_write(8'h04, 32'h0000_0007);
        repeat (5) @(negedge clk);
        bus_read(8'h10, v); check(v === 32'h9, "R4 write after timeout", v, 32'h9);
        // R10: unmapped offset, then hold
        bus_read(8'h3C, v); check(v === 32'h0, "R10 unmapped reads zero", v, 32'h0);
        codec_rdy = 0;
        repeat (2) @(negedge clk);
        check(bus_rdata === 32'h0, "R10 read data holds", bus_rdata, 32'h0);
        bus_read(8'h10, v); check(v === 32'h1, "R9 ready low", v, 32'h1);
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule